// File: doc/BRIEF.md
# Fixed-latency bus initiator

This block sits on the processor side of a small parallel system bus and turns local read and write requests into bus cycles. The bus has a memory-access strobe, a read-select line, a 20-bit byte address and an 8-bit data path. It has no acknowledge or ready wire. Every access therefore lasts a fixed number of clock cycles, set by the `LAT` parameter. The responder latches the operation type and address on the rising edge of the strobe.

A read drives the address with the strobe and read-select high, and releases the data path so the responder can drive it. It captures the returned byte at the end of the latency window and presents it for one cycle with a valid flag. A write drives the strobe with read-select low, and drives address and data together. It is posted: the requester's handshake completes in the accept cycle and no response ever comes back. While any access is in its window, `req_ready` is low and a pending request waits. Between accesses the strobe always drops for at least one cycle, so each access shows its own rising edge.

Top module: `fixed_lat_bus_init`

## Requirements
- R1: In the first cycle after synchronous reset, `bus_strobe`, `bus_read_sel`, `bus_doe` and `rdata_valid` are 0 and `req_ready` is 1.
- R2: A request accepted with `req_write`=0 (accept = `req_valid` and `req_ready` high at a rising edge) makes `bus_strobe`=1 and `bus_read_sel`=1 in the next cycle, with `bus_addr` equal to `req_addr` and `bus_doe`=0.
- R3: An accepted request with `req_write`=1 makes `bus_strobe`=1 and `bus_read_sel`=0 in the next cycle, with `bus_addr`=`req_addr`, `bus_dout`=`req_wdata` and `bus_doe`=1.
- R4: `bus_strobe` stays high for exactly `LAT` consecutive cycles per access. During those cycles `bus_addr`, `bus_read_sel` and `bus_dout` stay stable, whatever the request inputs do.
- R5: For a read, `rdata_valid` is high for exactly one cycle: the first cycle after the strobe falls, which is `LAT` cycles after the strobe first rose. `rdata` then holds the value `bus_din` had in the last strobe-high cycle.
- R6: `req_ready` is low from the cycle after an accept until the strobe falls. A request held during that time puts nothing on the bus and is accepted once `req_ready` returns.
- R7: With a request waiting, the strobe is low for exactly one cycle between two accesses.
- R8: A write never raises `rdata_valid` and leaves `rdata` unchanged.
- R9: While `req_valid` is 0, the request fields have no effect: the strobe stays 0, the data path stays released and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to store on a write |
| req_ready | output | 1 | Initiator can take a request |
| rdata | output | DATA_W | Byte returned by the last read |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` new |
| bus_strobe | output | 1 | Memory-access strobe |
| bus_read_sel | output | 1 | 1 = read access, 0 = write access |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Data driven toward the responder |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | DATA_W | Data driven by the responder |

## Verification
The assertions assume that `req_valid` is low or held with steady fields until accepted. They also assume a responder that only drives the data path while `bus_doe` is low and only needs the strobe-high window. The properties themselves only relate outputs to each other and to the accept handshake, so they do not depend on `bus_din` being meaningful. The bench drives requests at the falling edge and keeps `req_valid` asserted until the accept edge has passed. Its responder model puts a junk byte on `bus_din` in every strobe cycle except the last, so capturing early or late yields a visibly wrong `rdata`.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fbi_state_t;
endpackage

// File: rtl/fbi_lat_timer.sv
module fbi_lat_timer #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy,
  output logic last
);
  localparam int CW = (LAT < 1) ? 1 : $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  // cnt_q holds the index (1..LAT) of the current strobe-high cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(1);
    end else if (busy && !last) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign last = busy && (cnt_q == CW'(LAT));
endmodule

// File: rtl/fbi_rd_capture.sv
module fbi_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= take;
      if (take) begin
        rdata <= din;
      end
    end
  end
endmodule

// File: rtl/fixed_lat_bus_init.sv
module fixed_lat_bus_init
  import fbi_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              bus_strobe,
  output logic              bus_read_sel,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  fbi_state_t state_q;
  logic       start;
  logic       busy;
  logic       last;
  logic       finish;

  assign busy   = (state_q == ST_BUSY);
  assign start  = req_valid && req_ready;
  assign finish = busy && last;

  fbi_lat_timer #(.LAT(LAT)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .last (last)
  );

  fbi_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .take       (finish && bus_read_sel),
    .din        (bus_din),
    .rdata      (rdata),
    .rdata_valid(rdata_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      req_ready    <= 1'b1;
      bus_strobe   <= 1'b0;
      bus_read_sel <= 1'b0;
      bus_doe      <= 1'b0;
      bus_addr     <= '0;
      bus_dout     <= '0;
    end else if (start) begin
      state_q      <= ST_BUSY;
      req_ready    <= 1'b0;
      bus_strobe   <= 1'b1;
      bus_read_sel <= !req_write;
      bus_doe      <= req_write;
      bus_addr     <= req_addr;
      if (req_write) begin
        bus_dout <= req_wdata;
      end
    end else if (finish) begin
      // strobe drops for at least one cycle before the next access
      state_q      <= ST_IDLE;
      req_ready    <= 1'b1;
      bus_strobe   <= 1'b0;
      bus_read_sel <= 1'b0;
      bus_doe      <= 1'b0;
    end
  end
endmodule

// File: rtl/fbi_checker.sv
module fbi_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int LAT    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rdata_valid,
  input logic              bus_strobe,
  input logic              bus_read_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_doe
);
  localparam int HW = $clog2(LAT + 2) + 1;

  logic [HW-1:0] hi_cnt;

  // number of consecutive strobe-high cycles seen so far
  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else     hi_cnt <= bus_strobe ? hi_cnt + HW'(1) : '0;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_strobe && !bus_read_sel && !bus_doe && !rdata_valid && req_ready)); // R1
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (bus_read_sel || !bus_strobe) |-> !bus_doe); // R2
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && !bus_read_sel) |-> bus_doe); // R3
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    bus_strobe |-> (hi_cnt < HW'(LAT))); // R4
  AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_strobe) |-> (hi_cnt == HW'(LAT))); // R4
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && $past(bus_strobe)) |-> ($stable(bus_addr) && $stable(bus_read_sel) && $stable(bus_dout))); // R4
  AST_RVALID_TIMING: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |-> ((hi_cnt == HW'(LAT)) && $past(bus_read_sel))); // R5
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |=> !rdata_valid); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    bus_strobe |-> !req_ready); // R6
  AST_ACCEPT_RISES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> $rose(bus_strobe)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && req_ready) |=> !bus_strobe); // R9
endmodule

bind fixed_lat_bus_init fbi_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LAT   (LAT)
) u_fbi_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rdata_valid (rdata_valid),
  .bus_strobe  (bus_strobe),
  .bus_read_sel(bus_read_sel),
  .bus_addr    (bus_addr),
  .bus_dout    (bus_dout),
  .bus_doe     (bus_doe)
);

// File: tb/test_fixed_lat_bus_init.sv
module test_fixed_lat_bus_init;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready;
  logic [DATA_W-1:0] rdata;
  logic              rdata_valid;
  logic              bus_strobe;
  logic              bus_read_sel;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_doe;
  logic [DATA_W-1:0] bus_din = 8'hEE;

  int tests  = 0;
  int fails  = 0;
  int sc_cnt = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fixed_lat_bus_init #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) i_fixed_lat_bus_init (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rdata(rdata), .rdata_valid(rdata_valid), .bus_strobe(bus_strobe),
    .bus_read_sel(bus_read_sel), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  function automatic logic [DATA_W-1:0] mem_val(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // responder model: real byte only in the last strobe-high cycle
  always @(negedge clk) begin
    if (rst || !bus_strobe) sc_cnt = 0;
    else                    sc_cnt = sc_cnt + 1;
    bus_din = (bus_strobe && bus_read_sel && sc_cnt == LAT) ? mem_val(bus_addr) : 8'hEE;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bus_strobe == 1'b0, "R1 strobe", 32'(bus_strobe), 0);
    check(bus_read_sel == 1'b0, "R1 read_sel", 32'(bus_read_sel), 0);
    check(bus_doe == 1'b0, "R1 doe", 32'(bus_doe), 0);
    check(rdata_valid == 1'b0, "R1 rdata_valid", 32'(rdata_valid), 0);
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
  endtask

  task automatic t_read(input logic [ADDR_W-1:0] a);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'hA5;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    check(bus_strobe && bus_read_sel, "R2 strobe/read_sel", {bus_strobe, bus_read_sel}, 3);
    check(bus_addr == a, "R2 addr", 32'(bus_addr), 32'(a));
    check(bus_doe == 1'b0, "R2 doe", 32'(bus_doe), 0);
    check(req_ready == 1'b0, "R6 ready low", 32'(req_ready), 0);
    for (int k = 2; k <= LAT; k++) begin
      @(negedge clk);
      check(bus_strobe == 1'b1, "R4 strobe held", 32'(bus_strobe), 1);
      check(bus_addr == a, "R4 addr stable", 32'(bus_addr), 32'(a));
      check(rdata_valid == 1'b0, "R5 no early valid", 32'(rdata_valid), 0);
    end
    @(negedge clk);
    check(bus_strobe == 1'b0, "R4 strobe drops", 32'(bus_strobe), 0);
    check(rdata_valid == 1'b1, "R5 valid", 32'(rdata_valid), 1);
    check(rdata == mem_val(a), "R5 rdata", 32'(rdata), 32'(mem_val(a)));
    check(req_ready == 1'b1, "R6 ready back", 32'(req_ready), 1);
    @(negedge clk);
    check(rdata_valid == 1'b0, "R5 pulse", 32'(rdata_valid), 0);
  endtask

  task automatic t_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] keep;
    keep = rdata;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d;
    check(bus_strobe && !bus_read_sel, "R3 strobe/read_sel", {bus_strobe, bus_read_sel}, 2);
    check(bus_addr == a, "R3 addr", 32'(bus_addr), 32'(a));
    check(bus_dout == d && bus_doe, "R3 dout/doe", {bus_doe, bus_dout}, {1'b1, d});
    for (int k = 1; k <= LAT + 1; k++) begin
      if (k > 1) @(negedge clk);
      check(rdata_valid == 1'b0, "R8 no valid", 32'(rdata_valid), 0);
      if (k <= LAT) check(bus_dout == d, "R4 dout stable", 32'(bus_dout), 32'(d));
    end
    check(rdata == keep, "R8 rdata kept", 32'(rdata), 32'(keep));
    check(bus_strobe == 1'b0 && req_ready, "R6 write window ends", {bus_strobe, req_ready}, 1);
  endtask

  task automatic t_back_to_back(input logic [ADDR_W-1:0] a1, input logic [ADDR_W-1:0] a2);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a1; req_wdata = 8'h5A;
    @(negedge clk);
    req_write = 1'b0; req_addr = a2;   // held read waits behind the write
    for (int i = 1; i <= 2 * LAT + 2; i++) begin
      if (i > 1) @(negedge clk);
      if (i <= LAT) begin
        check(bus_strobe && bus_addr == a1, "R6 held request off bus", 32'(bus_addr), 32'(a1));
        check(req_ready == 1'b0, "R6 ready low while held", 32'(req_ready), 0);
      end else if (i == LAT + 1) begin
        check(bus_strobe == 1'b0, "R7 one-cycle gap", 32'(bus_strobe), 0);
      end else if (i <= 2 * LAT + 1) begin
        check(bus_strobe && bus_read_sel && bus_addr == a2, "R7 second access", 32'(bus_addr), 32'(a2));
        if (i == LAT + 2) req_valid = 1'b0;
      end else begin
        check(rdata_valid && rdata == mem_val(a2), "R5 b2b rdata", 32'(rdata), 32'(mem_val(a2)));
      end
    end
    @(negedge clk);
  endtask

  task automatic t_idle();
    req_valid = 1'b0; req_write = 1'b1; req_addr = 20'hABCDE; req_wdata = 8'h77;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      req_addr = req_addr + 20'h111;
      check(!bus_strobe && !bus_doe && req_ready, "R9 idle", {bus_strobe, bus_doe, req_ready}, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read(20'h12345);
    t_write(20'h0F0F0, 8'hC3);
    t_read(20'hFFFFF);
    t_back_to_back(20'h00100, 20'h4A2B7);
    t_idle();
    t_read(20'h00000);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule